// File: doc/BRIEF.md
# Voice Amplitude Envelope Generator

This block shapes the loudness of one audio voice over time. A key-on pulse starts the envelope from silence. On every sample tick after that, the envelope moves one step through its phases: it rises in attack, falls in decay until it reaches a programmed sustain level, then holds, rises or falls in sustain. A key-off pulse sends it into release, which falls until the envelope would go below zero. At that point the voice reports that it has finished.

Every step size comes from one shared exponential rate ladder with 160 entries. This ladder is computed by arithmetic from the entry index, so the block holds no table storage. The index for each step is built from the inverted rate field of the current phase. In the exponentially decreasing modes the index also gets an extra offset, picked by the top three magnitude bits of the envelope, so large envelopes fall in larger steps. Two 16-bit configuration words set the rates, the slope modes and the sustain level. They are read live on each tick.

The outputs are a 10-bit volume, which is the 32-bit envelope shifted right by 21, the upper 16 bits of the envelope for read-back, and a finished flag.

Top module: `env_gen`

## Requirements
- R1: After synchronous reset, the volume, the upper envelope word and the finished flag are all zero. The block is idle, and ticks leave it unchanged.
- R2: Step ladder entry i is zero for i < 32. For i >= 32, let t = i - 32. The entry is (4 + t mod 4) shifted left by floor(t/4), capped at 0x3FFFFFFF. So entry 143 is 0x38000000 and entry 144 is 0x3FFFFFFF.
- R3: A key-on pulse sets the envelope to zero, enters attack and clears the finished flag. A key-on wins over a key-off in the same cycle.
- R4: Attack uses word A bit 15 (exponential), bits 14:8 (rate). Each tick it adds ladder entry (rate XOR 0x7F) + 16. In exponential mode, once the envelope is at least 0x60000000, it adds entry (rate XOR 0x7F) + 8 instead.
- R5: If an attack addition would pass 0x7FFFFFFF, the envelope becomes 0x7FFFFFFF and the phase becomes decay.
- R6: Decay uses word A bits 7:4 (rate). Each tick it subtracts entry 4·(rate XOR 0x1F) + 8 + k, with the result clamped at zero. k is taken from envelope bits 30:28 using the map 0→0, 1→4, 2→6, 3→8, 4→9, 5→10, 6→11, 7→12.
- R7: After a decay step, the phase becomes sustain if envelope bits 30:27 are less than or equal to the sustain level in word A bits 3:0.
- R8: Sustain uses word B bit 15 (exponential), bit 14 (1 = decrease), bits 12:6 (rate). An increase follows the attack rules but saturates at 0x7FFFFFFF and stays in sustain. A linear decrease subtracts entry (rate XOR 0x7F) + 17. An exponential decrease subtracts entry (rate XOR 0x7F) + 5 + k. Both decreases clamp at zero.
- R9: A key-off pulse, while the voice is not idle, enters release without changing the envelope, so the next tick takes a release step. Release uses word B bit 5 (exponential), bits 4:0 (rate). It subtracts entry 4·(rate XOR 0x1F) + 20 in linear mode or + 8 + k in exponential mode. While release runs, the envelope never rises. A key-off while idle has no effect.
- R10: When a release step would take the envelope below zero, the envelope becomes zero, the finished flag is set and the block goes idle. It stays that way until the next key-on.
- R11: The volume equals envelope bits 30:21, and the upper word equals envelope bits 31:16. Neither output changes in a cycle without a tick or a key-on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_a_i | input | 16 | Attack mode and rate, decay rate, sustain level |
| cfg_b_i | input | 16 | Sustain mode, direction and rate; release mode and rate |
| key_on_i | input | 1 | Start-of-note pulse |
| key_off_i | input | 1 | End-of-note pulse |
| tick_i | input | 1 | Sample-tick strobe; one envelope step per tick |
| vol_o | output | 10 | Envelope volume (envelope >> 21) |
| env_hi_o | output | 16 | Upper 16 bits of the envelope |
| finished_o | output | 1 | Voice has finished its release |

## Verification
The hardest cases to reach from the ports are the exponential decreases at each top-bit band, and a sustain increase that saturates. Both need a long run of ticks at a fast rate, with the right mode bits, before the phase of interest is even reached. The stimulus biases the random rate fields toward the fast end of the ladder, keys voices back on soon after they finish, and changes the configuration words rarely. As a result, many voices pass through every phase with every mode bit setting. A directed sequence pins down the overflow clamp, the attack knee and the underflow finish cycle by cycle, using values worked out by hand.

// File: rtl/env_gen_pkg.sv
package env_gen_pkg;

    localparam int ENV_W    = 32;
    localparam int IDX_W    = 8;
    localparam int TBL_LEN  = 160;
    localparam int TBL_FLAT = 32;
    localparam logic [ENV_W-1:0] STEP_CAP = 32'h3FFF_FFFF;
    localparam logic [ENV_W-1:0] ENV_MAX  = 32'h7FFF_FFFF;
    localparam logic [ENV_W-1:0] EXP_KNEE = 32'h6000_0000;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ATK,
        PH_DEC,
        PH_SUS,
        PH_REL
    } phase_e;

    typedef struct packed {
        logic       atk_exp;
        logic [6:0] atk_rate;
        logic [3:0] dec_rate;
        logic [3:0] sus_lvl;
    } cfg_a_t;

    typedef struct packed {
        logic       sus_exp;
        logic       sus_down;
        logic       spare;
        logic [6:0] sus_rate;
        logic       rel_exp;
        logic [4:0] rel_rate;
    } cfg_b_t;

    // extra ladder offset chosen by envelope magnitude band
    function automatic logic [3:0] band_k(input logic [2:0] band);
        case (band)
            3'd0:    return 4'd0;
            3'd1:    return 4'd4;
            3'd2:    return 4'd6;
            3'd3:    return 4'd8;
            3'd4:    return 4'd9;
            3'd5:    return 4'd10;
            3'd6:    return 4'd11;
            default: return 4'd12;
        endcase
    endfunction

    // closed form of the step ladder: (4 + t%4) << (t/4), capped
    function automatic logic [ENV_W-1:0] ladder(input logic [IDX_W-1:0] idx);
        logic [6:0] t;
        logic [4:0] sh;
        if (idx < IDX_W'(TBL_FLAT) || idx >= IDX_W'(TBL_LEN)) return '0;
        t  = 7'(idx - IDX_W'(TBL_FLAT));
        sh = t[6:2];
        if (sh >= 5'd28) return STEP_CAP;
        return ENV_W'({1'b1, t[1:0]}) << sh;
    endfunction

endpackage

// File: rtl/env_step_sel.sv
module env_step_sel
    import env_gen_pkg::*;
(
    input  phase_e                  phase,
    input  cfg_a_t                  ca,
    input  cfg_b_t                  cb,
    input  logic [ENV_W-1:0]        env,
    output logic [IDX_W-1:0]        idx,
    output logic                    add
);
    logic [3:0]       k;
    logic [IDX_W-1:0] inv_a;
    logic [IDX_W-1:0] inv_s;
    logic [IDX_W-1:0] quad_d;
    logic [IDX_W-1:0] quad_r;
    logic             above_knee;

    assign k          = band_k(env[30:28]);
    assign inv_a      = {1'b0, ca.atk_rate ^ 7'h7F};
    assign inv_s      = {1'b0, cb.sus_rate ^ 7'h7F};
    assign quad_d     = {1'b0, 1'b1, ~ca.dec_rate, 2'b00};
    assign quad_r     = {1'b0, cb.rel_rate ^ 5'h1F, 2'b00};
    assign above_knee = env >= EXP_KNEE;

    always_comb begin
        idx = '0;
        add = 1'b0;
        case (phase)
            PH_ATK: begin
                add = 1'b1;
                idx = (ca.atk_exp && above_knee) ? inv_a + 8'd8 : inv_a + 8'd16;
            end
            PH_DEC: begin
                idx = quad_d + 8'd8 + {4'b0, k};
            end
            PH_SUS: begin
                add = !cb.sus_down;
                if (!cb.sus_down)
                    idx = (cb.sus_exp && above_knee) ? inv_s + 8'd8 : inv_s + 8'd16;
                else if (cb.sus_exp)
                    idx = inv_s + 8'd5 + {4'b0, k};
                else
                    idx = inv_s + 8'd17;
            end
            PH_REL: begin
                idx = cb.rel_exp ? quad_r + 8'd8 + {4'b0, k} : quad_r + 8'd20;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/env_rate_gen.sv
module env_rate_gen
    import env_gen_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [ENV_W-1:0] step
);
    assign step = ladder(idx);
endmodule

// File: rtl/env_gen.sv
module env_gen
    import env_gen_pkg::*;
#(
    parameter int VOL_W   = 10,
    parameter int VOL_LSB = 21,
    parameter int HI_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      cfg_a_i,
    input  logic [15:0]      cfg_b_i,
    input  logic             key_on_i,
    input  logic             key_off_i,
    input  logic             tick_i,
    output logic [VOL_W-1:0] vol_o,
    output logic [HI_W-1:0]  env_hi_o,
    output logic             finished_o
);
    localparam int WIDE_W = ENV_W + 1;

    cfg_a_t ca;
    cfg_b_t cb;
    logic   unused_spare;

    assign ca           = cfg_a_t'(cfg_a_i);
    assign cb           = cfg_b_t'(cfg_b_i);
    assign unused_spare = cb.spare;

    phase_e           phase_q, phase_d;
    logic [ENV_W-1:0] env_q, env_d;
    logic             fin_q, fin_d;

    logic [IDX_W-1:0]  idx;
    logic              add;
    logic [ENV_W-1:0]  step;
    logic [WIDE_W-1:0] sum_w, diff_w;
    logic [ENV_W-1:0]  dec_val;

    env_step_sel u_sel (
        .phase (phase_q),
        .ca    (ca),
        .cb    (cb),
        .env   (env_q),
        .idx   (idx),
        .add   (add)
    );

    env_rate_gen u_rate (
        .idx  (idx),
        .step (step)
    );

    assign sum_w   = {1'b0, env_q} + {1'b0, step};
    assign diff_w  = {1'b0, env_q} - {1'b0, step};
    assign dec_val = diff_w[WIDE_W-1] ? '0 : diff_w[ENV_W-1:0];

    always_comb begin
        phase_d = phase_q;
        env_d   = env_q;
        fin_d   = fin_q;
        if (key_on_i) begin
            phase_d = PH_ATK;
            env_d   = '0;
            fin_d   = 1'b0;
        end else if (key_off_i && phase_q != PH_IDLE) begin
            phase_d = PH_REL;
        end else if (tick_i) begin
            case (phase_q)
                PH_ATK: begin
                    if (sum_w > {1'b0, ENV_MAX}) begin
                        env_d   = ENV_MAX;
                        phase_d = PH_DEC;
                    end else begin
                        env_d = sum_w[ENV_W-1:0];
                    end
                end
                PH_DEC: begin
                    env_d = dec_val;
                    if (dec_val[30:27] <= ca.sus_lvl) phase_d = PH_SUS;
                end
                PH_SUS: begin
                    if (add)
                        env_d = (sum_w > {1'b0, ENV_MAX}) ? ENV_MAX : sum_w[ENV_W-1:0];
                    else
                        env_d = dec_val;
                end
                PH_REL: begin
                    env_d = dec_val;
                    if (diff_w[WIDE_W-1]) begin
                        phase_d = PH_IDLE;
                        fin_d   = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            env_q   <= '0;
            fin_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            env_q   <= env_d;
            fin_q   <= fin_d;
        end
    end

    assign vol_o      = env_q[VOL_LSB +: VOL_W];
    assign env_hi_o   = env_q[ENV_W-1 -: HI_W];
    assign finished_o = fin_q;
endmodule

// File: rtl/env_gen_chk.sv
module env_gen_chk #(
    parameter int VOL_W   = 10,
    parameter int VOL_LSB = 21,
    parameter int HI_W    = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             key_on_i,
    input logic             key_off_i,
    input logic             tick_i,
    input logic [VOL_W-1:0] vol_o,
    input logic [HI_W-1:0]  env_hi_o,
    input logic             finished_o
);
    localparam int HI_LSB = 32 - HI_W;

    logic rel_seen;
    always_ff @(posedge clk) begin
        if (rst || key_on_i) rel_seen <= 1'b0;
        else if (key_off_i)  rel_seen <= 1'b1;
    end

    // R3: key-on clears envelope and finish flag
    a_r3_key_on_clears: assert property (@(posedge clk) disable iff (rst)
        key_on_i |=> (env_hi_o == '0 && vol_o == '0 && !finished_o));

    // R9: no rise once released
    a_r9_release_no_rise: assert property (@(posedge clk) disable iff (rst)
        (rel_seen && !key_on_i) |=> (env_hi_o <= $past(env_hi_o)));

    // R10: finishing leaves a zero envelope
    a_r10_finish_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(finished_o) |-> (env_hi_o == '0));

    // R10: finish flag holds until key-on
    a_r10_finish_holds: assert property (@(posedge clk) disable iff (rst)
        (finished_o && !key_on_i) |=> finished_o);

    // R11: outputs hold without tick or key-on
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !key_on_i) |=> ($stable(env_hi_o) && $stable(finished_o)));

    // R11: volume and upper word come from the same envelope
    a_r11_vol_match: assert property (@(posedge clk) disable iff (rst)
        vol_o == env_hi_o[VOL_LSB-HI_LSB +: VOL_W]);
endmodule

bind env_gen env_gen_chk #(.VOL_W(VOL_W), .VOL_LSB(VOL_LSB), .HI_W(HI_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .key_on_i   (key_on_i),
    .key_off_i  (key_off_i),
    .tick_i     (tick_i),
    .vol_o      (vol_o),
    .env_hi_o   (env_hi_o),
    .finished_o (finished_o)
);

// File: tb/env_gen_tb_top.sv
`timescale 1ns/1ps
module env_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_a = '0;
    logic [15:0] cfg_b = '0;
    logic        kon = 1'b0, koff = 1'b0, tk = 1'b0;
    logic [9:0]  vol;
    logic [15:0] hi;
    logic        fin;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    env_gen dut_i (
        .clk(clk), .rst(rst), .cfg_a_i(cfg_a), .cfg_b_i(cfg_b),
        .key_on_i(kon), .key_off_i(koff), .tick_i(tk),
        .vol_o(vol), .env_hi_o(hi), .finished_o(fin)
    );

    // bench model state
    longint tbl [160];
    longint menv;
    int     mph;
    bit     mfin;
    localparam longint CAPV = 64'h3FFF_FFFF;
    localparam longint TOPV = 64'h7FFF_FFFF;

    function automatic void build_tbl();
        longint r = 3, rs = 1;
        int rd = 0;
        for (int i = 0; i < 32; i++) tbl[i] = 0;
        for (int i = 32; i < 160; i++) begin
            if (r < CAPV) begin
                r += rs;
                rd++;
                if (rd == 5) begin rd = 1; rs *= 2; end
            end
            if (r > CAPV) r = CAPV;
            tbl[i] = r;
        end
    endfunction

    function automatic int kk(longint e);
        int band = int'((e >> 28) & 7);
        int lst [8] = '{0, 4, 6, 8, 9, 10, 11, 12};
        return lst[band];
    endfunction

    function automatic void mstep(logic [15:0] a, logic [15:0] b, bit on, bit off, bit t);
        int ar = int'(a[14:8]), dr = int'(a[7:4]), sl = int'(a[3:0]);
        int sr = int'(b[12:6]), rr = int'(b[4:0]);
        int ix;
        int kb = kk(menv);
        if (on) begin
            menv = 0; mph = 1; mfin = 0;
        end else if (off && mph != 0) begin
            mph = 4;
        end else if (t) begin
            case (mph)
                1: begin
                    ix = (a[15] && menv >= 64'h6000_0000) ? (ar ^ 127) - 'h18 + 32 : (ar ^ 127) - 'h10 + 32;
                    menv += tbl[ix];
                    if (menv > TOPV) begin menv = TOPV; mph = 2; end
                end
                2: begin
                    ix = 4 * (dr ^ 31) - 'h18 + kb + 32;
                    menv -= tbl[ix];
                    if (menv < 0) menv = 0;
                    if (((menv >> 27) & 15) <= sl) mph = 3;
                end
                3: begin
                    if (!b[14]) begin
                        ix = (b[15] && menv >= 64'h6000_0000) ? (sr ^ 127) - 'h18 + 32 : (sr ^ 127) - 'h10 + 32;
                        menv += tbl[ix];
                        if (menv > TOPV) menv = TOPV;
                    end else begin
                        ix = b[15] ? (sr ^ 127) - 'h1B + kb + 32 : (sr ^ 127) - 'h0F + 32;
                        menv -= tbl[ix];
                        if (menv < 0) menv = 0;
                    end
                end
                4: begin
                    ix = b[5] ? 4 * (rr ^ 31) - 'h18 + kb + 32 : 4 * (rr ^ 31) - 'h0C + 32;
                    menv -= tbl[ix];
                    if (menv < 0) begin menv = 0; mph = 0; mfin = 1; end
                end
                default: ;
            endcase
        end
    endfunction

    task automatic chk(string tag, logic [15:0] act_hi, logic [15:0] exp_hi,
                       logic act_f, logic exp_f, logic [9:0] act_v, logic [9:0] exp_v);
        checks++;
        if (act_hi !== exp_hi || act_f !== exp_f || act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: hi=%h fin=%0d vol=%h expected hi=%h fin=%0d vol=%h",
                     tag, act_hi, act_f, act_v, exp_hi, exp_f, exp_v);
        end
    endtask

    task automatic cyc(bit on, bit off, bit t);
        @(negedge clk);
        kon = on; koff = off; tk = t;
        mstep(cfg_a, cfg_b, on, off, t);
        @(posedge clk);
        #1;
    endtask

    task automatic dchk(string tag, logic [15:0] eh, logic ef);
        chk(tag, hi, eh, fin, ef, vol, eh[14:5]);
    endtask

    function automatic string ptag(int p);
        case (p)
            1: return "R4";
            2: return "R6";
            3: return "R8";
            4: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [15:0] rand_a();
        logic [6:0] ar = ($urandom % 2) ? 7'($urandom % 16) : 7'($urandom);
        logic [3:0] dr = ($urandom % 2) ? 4'($urandom % 4) : 4'($urandom);
        return {1'($urandom), ar, dr, 4'($urandom)};
    endfunction

    function automatic logic [15:0] rand_b();
        logic [6:0] sr = ($urandom % 2) ? 7'($urandom % 16) : 7'($urandom);
        logic [4:0] rr = ($urandom % 2) ? 5'($urandom % 8) : 5'($urandom);
        return {2'($urandom), 1'b0, sr, 1'($urandom), rr};
    endfunction

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        build_tbl();
        void'($urandom(32'd20240611));
        menv = 0; mph = 0; mfin = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
        dchk("R1 reset", 16'h0000, 1'b0);
        cyc(0, 0, 1); cyc(0, 0, 1);
        dchk("R1 idle tick", 16'h0000, 1'b0);
        cyc(0, 1, 0); cyc(0, 0, 1);
        dchk("R9 key-off idle ignored", 16'h0000, 1'b0);

        cfg_a = 16'h0000; cfg_b = 16'h0000;
        cyc(1, 0, 0);
        dchk("R3 key-on", 16'h0000, 1'b0);
        cyc(0, 0, 1); dchk("R2 entry 143 attack", 16'h3800, 1'b0);
        cyc(0, 0, 1); dchk("R4 linear attack", 16'h7000, 1'b0);
        cyc(0, 0, 1); dchk("R5 overflow clamp", 16'h7FFF, 1'b0);
        cyc(0, 0, 1); dchk("R6 decay band 7", 16'h4000, 1'b0);
        cyc(0, 0, 1); dchk("R6 decay band 4", 16'h1800, 1'b0);
        cyc(0, 0, 1); dchk("R6 decay band 1", 16'h0800, 1'b0);
        cyc(0, 0, 1); dchk("R7 decay to zero", 16'h0000, 1'b0);
        cyc(0, 0, 1); dchk("R8 sustain increase", 16'h3800, 1'b0);
        cyc(0, 1, 0); dchk("R9 key-off holds envelope", 16'h3800, 1'b0);
        cyc(0, 0, 1); dchk("R10 release underflow", 16'h0000, 1'b1);
        cyc(0, 0, 1); dchk("R10 stays finished", 16'h0000, 1'b1);
        cyc(1, 1, 0); dchk("R3 key-on over key-off", 16'h0000, 1'b0);
        cyc(0, 0, 1); dchk("R3 attack after priority", 16'h3800, 1'b0);

        cfg_a = 16'h7F00;
        cyc(1, 0, 0); cyc(0, 0, 1); cyc(0, 0, 1);
        dchk("R2 zero entry 16", 16'h0000, 1'b0);

        cfg_a = 16'h8000;
        cyc(1, 0, 0); cyc(0, 0, 1); cyc(0, 0, 1);
        dchk("R4 exp below knee", 16'h7000, 1'b0);
        cyc(0, 0, 1);
        dchk("R4 exp above knee", 16'h7E00, 1'b0);
        cyc(0, 0, 0);
        dchk("R11 hold without tick", 16'h7E00, 1'b0);

        for (int n = 0; n < 150000; n++) begin
            string tag;
            bit on, off, t;
            if ($urandom % 600 == 0) cfg_a = rand_a();
            if ($urandom % 600 == 0) cfg_b = rand_b();
            on  = ($urandom % 500 == 0) || (mph == 0 && $urandom % 30 == 0);
            off = ($urandom % 300 == 0);
            t   = ($urandom % 3 != 0);
            tag = ptag(mph);
            cyc(on, off, t);
            chk(tag, hi, 16'((menv >> 16) & 64'hFFFF), fin, mfin,
                vol, 10'((menv >> 21) & 64'h3FF));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule